// File: doc/BRIEF.md
# Cascaded Rate Enable Generator

This block runs entirely on one 1.8432 MHz master clock and turns it into three periodic enable pulses for the logic around it. Every enable is exactly one master cycle wide, so the logic in every rate domain stays on the master clock and the enable acts as its clock gate. No second clock tree is needed.

The chain has three stages. A divide-by-2 stage gives the 921.6 kHz system-rate enable. A divide-by-12 stage gives the 153.6 kHz serial oversampling enable, which is sixteen ticks per bit at 9600 baud. The audio sample enable is not divided from the master clock. A divide-by-16 stage counts serial ticks to make it, which gives 9600 Hz. Each sample pulse therefore falls in the same cycle as a serial pulse. The serial pulse is deliberately narrow and far from 50% duty, because receivers that sample on a tick only need an edge per period. A synchronous reset clears every counter and holds all enables low.

Top module: `rate_enable_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after `rst` falls, `sys_en`, `ser_en` and `smp_en` are all low.
- R2: `sys_en` goes high after the second rising edge following reset release and then alternates every master cycle: high one cycle, low the next.
- R3: `ser_en` is high after rising edge n (counted from 1 after reset release) exactly when n is a multiple of 12. Every serial pulse coincides with a system pulse.
- R4: `smp_en` is high exactly on the serial pulse that completes every 16th serial period, i.e. when n is a multiple of 192. It is never high without `ser_en`.
- R5: Each enable stays high for one master cycle and never for two cycles in a row.
- R6: Consecutive `smp_en` pulses are exactly 192 master cycles apart, and each sample period holds exactly 96 `sys_en` pulses and 16 `ser_en` pulses.
- R7: Asserting `rst` in mid-run discards the current phase. After release, the pulse pattern restarts exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1.8432 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_en | output | 1 | System-rate enable, master/2 |
| ser_en | output | 1 | Serial oversampling enable, master/12 |
| smp_en | output | 1 | Audio sample enable, serial/16 |

## Verification
The bench counts every master edge from reset release through four full sample periods. It predicts each enable from the edge number alone, so a stage that wraps one count early or late, or that starts with its first pulse one cycle off, shows up as a mismatch at the first wrap. It measures the spacing between sample pulses and counts the system and serial pulses inside each sample period. A sample stage that counted master cycles instead of serial ticks, or whose pulse was one cycle out of step with the serial pulse, would break both the spacing and the coincidence. A reset applied mid-period, followed by a second sweep, catches a counter that keeps a stale phase across reset. It also catches an enable that leaks out in the first cycle after release.

// File: rtl/rate_enable_pkg.sv
package rate_enable_pkg;

    // Division ratios for the three stages
    localparam int unsigned SYS_RATIO_DEF = 2;   // master -> system rate
    localparam int unsigned SER_RATIO_DEF = 12;  // master -> serial oversampling
    localparam int unsigned SMP_RATIO_DEF = 16;  // serial -> audio sample

    // Bundle of enable outputs
    typedef struct packed {
        logic sys;
        logic ser;
        logic smp;
    } tick_bundle_t;

endpackage

// File: rtl/rate_div_stage.sv
module rate_div_stage #(
    parameter int unsigned RATIO = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,   // advance the count on this cycle
    output logic wrap_o,   // combinational: this step completes a period
    output logic pulse_o   // registered one-cycle enable
);

    localparam int unsigned CNT_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } stage_state_t;

    stage_state_t state_d, state_q;
    logic         wrap_d;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        wrap_d        = step_i && (state_q.cnt == LAST);
        if (step_i) begin
            if (wrap_d) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
            state_d.pulse = wrap_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wrap_o  = wrap_d;
    assign pulse_o = state_q.pulse;

    initial begin
        assert (RATIO >= 2)
            else $error("rate_div_stage: RATIO must be at least 2");
    end

    // count never leaves its range (R6)
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        state_q.cnt <= LAST);

    // a pulse is never stretched over two cycles (R5)
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // a pulse follows only a cycle in which the stage was stepped (R3)
    assert_pulse_needs_step_R3: assert property (@(posedge clk) disable iff (rst)
        !rst && !$past(rst) && pulse_o |-> $past(step_i));

endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen
    import rate_enable_pkg::*;
#(
    parameter int unsigned SYS_RATIO = SYS_RATIO_DEF,
    parameter int unsigned SER_RATIO = SER_RATIO_DEF,
    parameter int unsigned SMP_RATIO = SMP_RATIO_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic sys_en,
    output logic ser_en,
    output logic smp_en
);

    tick_bundle_t ticks;
    logic         sys_wrap;
    logic         ser_wrap;
    logic         smp_wrap;

    // system-rate stage, stepped every master cycle
    rate_div_stage #(.RATIO(SYS_RATIO)) i_sys_stage (
        .clk     (clk),
        .rst     (rst),
        .step_i  (1'b1),
        .wrap_o  (sys_wrap),
        .pulse_o (ticks.sys)
    );

    // serial oversampling stage, stepped every master cycle
    rate_div_stage #(.RATIO(SER_RATIO)) i_ser_stage (
        .clk     (clk),
        .rst     (rst),
        .step_i  (1'b1),
        .wrap_o  (ser_wrap),
        .pulse_o (ticks.ser)
    );

    // sample stage, stepped by the serial wrap so its pulse lands with the serial pulse
    rate_div_stage #(.RATIO(SMP_RATIO)) i_smp_stage (
        .clk     (clk),
        .rst     (rst),
        .step_i  (ser_wrap),
        .wrap_o  (smp_wrap),
        .pulse_o (ticks.smp)
    );

    assign sys_en = ticks.sys;
    assign ser_en = ticks.ser;
    assign smp_en = ticks.smp;

    // nothing fires on the first cycle after release (R1)
    assert_quiet_after_release_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sys_en && !ser_en && !smp_en);

    // system enable alternates once running (R2)
    assert_sys_alternates_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !sys_en |=> sys_en);

    // serial pulse lands on a system pulse (R3)
    assert_ser_on_sys_R3: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> sys_en);

    // sample pulse only together with a serial pulse (R4)
    assert_smp_on_ser_R4: assert property (@(posedge clk) disable iff (rst)
        smp_en |-> ser_en);

    // the sample wrap is always a serial wrap (R4)
    assert_smp_wrap_on_ser_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        smp_wrap |-> ser_wrap);

    // unused wrap of the system stage kept observable for the check below (R2)
    assert_sys_wrap_precedes_R2: assert property (@(posedge clk) disable iff (rst)
        sys_wrap |=> sys_en);

endmodule

// File: tb/test_rate_enable_gen.sv
module test_rate_enable_gen;

    localparam int SYS_N    = 2;
    localparam int SER_N    = 12;
    localparam int SMP_N    = 16;
    localparam int PERIOD   = SER_N * SMP_N;   // 192
    localparam int N_PERIOD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_en, ser_en, smp_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    rate_enable_gen i_rate_enable_gen (
        .clk    (clk),
        .rst    (rst),
        .sys_en (sys_en),
        .ser_en (ser_en),
        .smp_en (smp_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sweep cycles 1..limit after a reset release; outputs sampled at negedge
    task automatic sweep(input int limit, input string tag);
        int last_smp = 0;
        int sys_cnt  = 0;
        int ser_cnt  = 0;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) begin
                check("R1", {tag, " first cycle quiet"}, int'(sys_en | ser_en | smp_en), 0);
            end
            check("R2", {tag, " sys_en"}, int'(sys_en), int'(n % SYS_N == 0));
            check("R3", {tag, " ser_en"}, int'(ser_en), int'(n % SER_N == 0));
            check("R4", {tag, " smp_en"}, int'(smp_en), int'(n % PERIOD == 0));
            sys_cnt += int'(sys_en);
            ser_cnt += int'(ser_en);
            if (smp_en) begin
                check("R6", {tag, " sample spacing"}, n - last_smp, PERIOD);
                check("R6", {tag, " sys per period"}, sys_cnt, PERIOD / SYS_N);
                check("R6", {tag, " ser per period"}, ser_cnt, SMP_N);
                check("R4", {tag, " smp with ser"}, int'(ser_en), 1);
                last_smp = n;
                sys_cnt  = 0;
                ser_cnt  = 0;
            end
        end
    endtask

    initial begin
        // reset state (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset holds enables low", int'(sys_en | ser_en | smp_en), 0);
        rst = 1'b0;
        sweep(PERIOD * N_PERIOD, "run1");

        // mid-period reset (R7)
        repeat (77) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7", "enables low in reset", int'(sys_en | ser_en | smp_en), 0);
        end
        rst = 1'b0;
        sweep(PERIOD * 2, "R7 rerun");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule